// File: doc/BRIEF.md
# Camera byte-pair pixel assembler

This block sits directly behind the parallel port of an image sensor. The sensor presents one 8-bit byte per pixel clock, along with a line-valid strobe and a frame sync. An RGB565 pixel therefore takes two consecutive bytes. The block joins each pair into one 16-bit word, with the earlier byte in the upper half. Its output is a pixel stream at half the byte rate: a one-cycle enable marks each new word. Line-valid and frame sync are delayed so that they line up with the assembled data.

Everything runs in the pixel-clock domain. There is no derived half-rate clock. Downstream logic runs on the same clock and qualifies its work with the enable. The byte-pair phase is re-armed whenever line-valid is low. An odd stray byte at the end of one line therefore cannot shift the pairing of the next line. The reset is synchronous and active low.

Top module: `cam_pixel_pack`

## Requirements
- R1: While rst_n is low at a clock edge, that edge forces pix_valid, pix_data, pix_href and pix_vsync to 0.
- R2: For each output pixel, pix_data[15:8] holds the first byte of the pair and pix_data[7:0] holds the second byte. Both bytes are sampled on consecutive edges with cam_href high.
- R3: pix_valid is high for exactly one cycle. That cycle follows the edge that captured the second byte of a pair, giving one pulse per two line-valid bytes and never two pulses in a row.
- R4: pix_href and pix_vsync equal cam_href and cam_vsync as sampled on the previous edge, so they change in the same cycle as the pixel data register.
- R5: A low cam_href returns the pairing to the first-byte phase. The first byte after any low period is always taken as an upper byte, and a leftover odd byte at a line end is dropped without producing a pixel.
- R6: pix_data keeps its value in every cycle in which pix_valid is low.
- R7: Bytes presented while cam_href is low are ignored: they produce no pix_valid pulse and leave pix_data unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sensor pixel clock; all logic samples on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cam_data | input | 8 | Sensor byte bus |
| cam_href | input | 1 | Line-valid strobe, high while bytes of a line are on the bus |
| cam_vsync | input | 1 | Frame sync from the sensor |
| pix_data | output | 16 | Assembled RGB565 word, first byte in the upper half |
| pix_valid | output | 1 | One-cycle pulse when a new word is on pix_data |
| pix_href | output | 1 | Line-valid delayed by one cycle, aligned with pix_data |
| pix_vsync | output | 1 | Frame sync delayed by one cycle, aligned with pix_data |

## Verification
The bench targets lines with an odd number of bytes and line-valid dropping in the middle of a pair. A design that kept its phase across the gap would swap the halves of every later pixel, or would emit a pixel built from bytes of two different lines. Bytes that toggle while line-valid is low show whether idle bus traffic leaks into the data register or fires the enable. Frame sync toggling and a reset asserted mid-line check that the delayed qualifiers stay one cycle behind their inputs, and that reset leaves no half-captured byte behind.

// File: rtl/cam_pixel_pack_pkg.sv
// Shared definitions for the byte-pair pixel assembler.
// Assumes: a pixel is exactly two bus bytes, earlier byte is the upper half.
package cam_pixel_pack_pkg;
    // Which half of a pixel the next line-valid byte belongs to
    typedef enum logic {
        PH_UPPER = 1'b0,
        PH_LOWER = 1'b1
    } byte_phase_e;

    localparam int unsigned BYTES_PER_PIXEL = 2;
endpackage

// File: rtl/cam_pixel_phase.sv
// Byte-phase tracker. Decides whether the current line-valid byte is the
// upper or the lower half of a pixel. The phase is forced back to the upper
// half whenever line-valid is low.
// Assumes: synchronous active-low reset, one byte per clock while href is high.
module cam_pixel_phase
    import cam_pixel_pack_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic href,
    output logic take_upper,
    output logic take_lower
);
    byte_phase_e phase_q;

    // Strobes for the byte on the bus this cycle
    always_comb begin
        take_upper = href && (phase_q == PH_UPPER);
        take_lower = href && (phase_q == PH_LOWER);
    end

    // Advance the phase on each valid byte, re-arm it while href is low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_UPPER;
        end else if (!href) begin
            phase_q <= PH_UPPER;
        end else begin
            phase_q <= (phase_q == PH_UPPER) ? PH_LOWER : PH_UPPER;
        end
    end
endmodule

// File: rtl/cam_pixel_join.sv
// Byte joiner. Holds the upper byte, then writes the full word together with
// a one-cycle valid pulse when the lower byte arrives. The output word holds
// between pulses.
// Assumes: take_upper and take_lower are never high together.
module cam_pixel_join #(
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              take_upper,
    input  logic              take_lower,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid
);
    logic [BYTE_W-1:0] upper_q;

    // Park the upper byte until its partner arrives
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q <= '0;
        end else if (take_upper) begin
            upper_q <= byte_in;
        end
    end

    // Publish the joined word and pulse valid for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_out   <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= take_lower;
            if (take_lower) begin
                word_out <= {upper_q, byte_in};
            end
        end
    end
endmodule

// File: rtl/cam_sync_align.sv
// Qualifier aligner. Delays a bundle of sync strobes by one register stage
// so that they change in the same cycle as the joined word.
// Assumes: the joiner has exactly one register stage on its output.
module cam_sync_align #(
    parameter int unsigned N_SIG = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SIG-1:0] sig_in,
    output logic [N_SIG-1:0] sig_out
);
    genvar g;
    generate
        for (g = 0; g < N_SIG; g++) begin : g_stage
            // One flop per strobe, cleared by reset
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sig_out[g] <= 1'b0;
                end else begin
                    sig_out[g] <= sig_in[g];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/cam_pixel_pack.sv
// Top of the byte-pair pixel assembler. Joins two consecutive line-valid
// bytes into one RGB565 word, pulses pix_valid once per word, and delays
// line-valid and frame sync to line up with the word.
// Assumes: single pixel-clock domain, synchronous active-low reset.
module cam_pixel_pack #(
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] cam_data,
    input  logic              cam_href,
    input  logic              cam_vsync,
    output logic [WORD_W-1:0] pix_data,
    output logic              pix_valid,
    output logic              pix_href,
    output logic              pix_vsync
);
    logic take_upper;
    logic take_lower;
    logic [1:0] sync_d;

    cam_pixel_phase u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .href       (cam_href),
        .take_upper (take_upper),
        .take_lower (take_lower)
    );

    cam_pixel_join #(.BYTE_W(BYTE_W)) u_join (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_in    (cam_data),
        .take_upper (take_upper),
        .take_lower (take_lower),
        .word_out   (pix_data),
        .word_valid (pix_valid)
    );

    cam_sync_align #(.N_SIG(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sig_in  ({cam_vsync, cam_href}),
        .sig_out (sync_d)
    );

    // Unpack the delayed qualifiers
    always_comb begin
        pix_href  = sync_d[0];
        pix_vsync = sync_d[1];
    end
endmodule

// File: rtl/cam_pixel_pack_chk.sv
// Assertion checker for cam_pixel_pack, attached by bind.
module cam_pixel_pack_chk #(
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned WORD_W = 2 * BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [BYTE_W-1:0] cam_data,
    input logic              cam_href,
    input logic              cam_vsync,
    input logic [WORD_W-1:0] pix_data,
    input logic              pix_valid,
    input logic              pix_href,
    input logic              pix_vsync
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!pix_valid && pix_data == '0 && !pix_href && !pix_vsync));

    // R2
    byte_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> (pix_data[BYTE_W-1:0] == $past(cam_data)
                       && pix_data[WORD_W-1:BYTE_W] == $past(cam_data, 2)));

    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> !pix_valid);

    // R4
    href_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cam_href |=> pix_href);

    // R4
    vsync_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cam_vsync |=> pix_vsync);

    // R5
    line_start_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cam_href && !$past(cam_href)) |=> !pix_valid);

    // R6
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |-> $stable(pix_data));

    // R7
    idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cam_href |=> !pix_valid);
endmodule

bind cam_pixel_pack cam_pixel_pack_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cam_data  (cam_data),
    .cam_href  (cam_href),
    .cam_vsync (cam_vsync),
    .pix_data  (pix_data),
    .pix_valid (pix_valid),
    .pix_href  (pix_href),
    .pix_vsync (pix_vsync)
);

// File: tb/cam_pixel_pack_test.sv
module cam_pixel_pack_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cam_data = '0;
    logic        cam_href = 1'b0;
    logic        cam_vsync = 1'b0;
    logic [15:0] pix_data;
    logic        pix_valid;
    logic        pix_href;
    logic        pix_vsync;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit live = 1'b0;
    string data_req = "R2";
    int n_pix = 0;

    always #10 clk = ~clk;

    cam_pixel_pack uut (
        .clk(clk), .rst_n(rst_n), .cam_data(cam_data), .cam_href(cam_href),
        .cam_vsync(cam_vsync), .pix_data(pix_data), .pix_valid(pix_valid),
        .pix_href(pix_href), .pix_vsync(pix_vsync)
    );

    // Behavioural reference: queue of line-valid bytes awaiting a partner
    byte unsigned pend[$];
    logic [15:0] m_data = '0;
    bit m_valid = 0, m_href = 0, m_vsync = 0, m_idle = 0;

    always @(posedge clk) begin
        m_idle = !cam_href;
        if (!rst_n) begin
            pend.delete();
            m_data = '0; m_valid = 0; m_href = 0; m_vsync = 0;
        end else begin
            m_href = cam_href;
            m_vsync = cam_vsync;
            m_valid = 0;
            if (!cam_href) begin
                pend.delete();
            end else begin
                pend.push_back(cam_data);
                if (pend.size() == 2) begin
                    m_data = {pend[0], pend[1]};
                    m_valid = 1;
                    pend.delete();
                end
            end
        end
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Compare against the reference every cycle, away from the active edge
    always @(negedge clk) begin
        if (live && !done) begin
            check(pix_valid == m_valid, m_idle ? "R7" : "R3", "pix_valid", pix_valid, m_valid);
            if (m_valid) begin
                n_pix++;
                check(pix_data == m_data, data_req, "pix_data", pix_data, m_data);
            end else begin
                check(pix_data == m_data, m_idle ? "R7" : "R6", "pix_data hold", pix_data, m_data);
            end
            check(pix_href == m_href, "R4", "pix_href", pix_href, m_href);
            check(pix_vsync == m_vsync, "R4", "pix_vsync", pix_vsync, m_vsync);
        end
    end

    task automatic drive(logic [7:0] d, logic h, logic v);
        @(negedge clk);
        cam_data = d; cam_href = h; cam_vsync = v;
    endtask

    task automatic line(int nbytes, int seed);
        for (int i = 0; i < nbytes; i++) drive(8'((seed + i * 37) & 8'hFF), 1'b1, 1'b0);
        for (int i = 0; i < 3; i++) drive(8'(seed ^ (i * 91)), 1'b0, 1'b0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        // R1: reset state with busy inputs
        cam_data = 8'hA5; cam_href = 1'b1; cam_vsync = 1'b1;
        repeat (3) @(negedge clk);
        check(pix_valid == 0 && pix_data == 0 && !pix_href && !pix_vsync,
              "R1", "reset outputs", {pix_data, pix_valid, pix_href, pix_vsync}, 0);
        live = 1;
        drive(8'h00, 1'b0, 1'b1);
        rst_n = 1'b1;
        drive(8'h00, 1'b0, 1'b0);

        // R2: frame of even lines with distinct patterns
        drive(8'h00, 1'b0, 1'b1);
        drive(8'h00, 1'b0, 1'b1);
        for (int l = 0; l < 4; l++) line(16, l * 13 + 1);
        drive(8'hF8, 1'b1, 1'b0); drive(8'h1F, 1'b1, 1'b0);
        drive(8'hFF, 1'b1, 1'b0); drive(8'h00, 1'b1, 1'b0);
        drive(8'h00, 1'b1, 1'b0); drive(8'hFF, 1'b1, 1'b0);
        drive(8'h00, 1'b0, 1'b0);

        // R5: odd lines and mid-pair href drop
        data_req = "R5";
        line(7, 200);
        line(10, 77);
        drive(8'h11, 1'b1, 1'b0); drive(8'h22, 1'b0, 1'b0);
        drive(8'h33, 1'b1, 1'b0); drive(8'h44, 1'b1, 1'b0);
        drive(8'h55, 1'b0, 1'b0);
        line(1, 9);
        line(4, 150);

        // R7: bus toggling with href low, vsync toggling
        for (int i = 0; i < 12; i++) drive(8'(i * 29 + 3), 1'b0, 1'(i[1]));
        line(6, 60);

        // R1: reset in the middle of a pair
        data_req = "R1";
        drive(8'hC3, 1'b1, 1'b1);
        rst_n = 1'b0;
        drive(8'h3C, 1'b1, 1'b1);
        drive(8'h3C, 1'b1, 1'b1);
        rst_n = 1'b1;
        drive(8'hAB, 1'b1, 1'b0); drive(8'hCD, 1'b1, 1'b0);
        drive(8'hEF, 1'b1, 1'b0); drive(8'h01, 1'b1, 1'b0);
        drive(8'h00, 1'b0, 1'b0);
        repeat (3) drive(8'h00, 1'b0, 1'b0);

        check(n_pix > 40, "R3", "pixel count", n_pix, 41);
        done = 1;
        summary();
    end
endmodule